// File: doc/BRIEF.md
# Byte-Serial CRC-16 Check Engine

This block keeps a running 16-bit cyclic redundancy check over a byte stream that software pushes in one write at a time. Each write to the data-input register folds the low byte of the written word into the accumulator in a single clock cycle. The same write advances a 12-bit counter of accepted inputs. A write to the control register with its top bit set clears both the accumulator and the counter. Reading the control register returns the counter, and reading the result register returns the checksum with its final inversion applied.

The bus is a plain word-wide port. Writes use one select line per register, so a single cycle can address several registers at once. Reads use a separate two-bit address that selects the read data combinationally. The polynomial, the initial value, the output inversion and the bit order are compile-time parameters. The defaults are polynomial 0x1021 processed least-significant bit first, with initial value 0xFFFF and output inversion 0xFFFF. With these defaults the sequence 0xCC, 0xF5, 0xF1, 0xA7 yields 0x51DF. A startup routine can use that sequence as a self-test.

Top module: `crc_engine`

## Requirements
- R1: After the asynchronous active-low reset, the control register reads 0x0000 and the result register reads 0x0000, which is the initial value 0xFFFF inverted by 0xFFFF.
- R2: A write with `wrSel[0]` (control) high and `wrData[15]` set clears both the count and the accumulator by the next edge. A control write with bit 15 clear changes nothing.
- R3: A read at `rdAddr` 0 (control) returns the count in bits 11:0. Bits 15:12 always read 0, so the reset bit reads back as 0.
- R4: A write with `wrSel[1]` (data input) high folds `wrData[7:0]` into the accumulator, least significant bit first, with polynomial 0x1021. The count rises by one. Both take effect at the next clock edge. With no write, both hold their values.
- R5: Bits 15:8 of a data-input write have no influence on the checksum.
- R6: After a clear, the inputs 0xCC, 0xF5, 0xF1 and 0xA7 give a count of 4 and a result-register value of 0x51DF.
- R7: The count stops at 0xFFF and does not wrap. The checksum keeps updating on later inputs.
- R8: When one cycle selects both the control and the data-input registers and sets bit 15, the clear wins and the byte is discarded. If bit 15 is clear in that cycle, the byte is accepted.
- R9: Writes through `wrSel[2]` (result register) are ignored. Reads at `rdAddr` 1 (data input) and 3 return 0, and `rdAddr` 2 returns the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrSel | input | 3 | Write strobes: bit 0 control, bit 1 data input, bit 2 result (read-only) |
| wrData | input | 16 | Write data shared by all selected registers |
| rdAddr | input | 2 | Read address: 0 control, 1 data input, 2 result, 3 unmapped |
| rdData | output | 16 | Combinational read data for `rdAddr` |

## Verification
The clear request and the byte feed can land in the same cycle, because the write port drives per-register select lines. The bench raises both selects in one write, once with bit 15 set and once with it clear. After the set case it expects a zero count and the inverted initial value. After the clear case it expects a count of one and the reference checksum of the low byte. A separate bench model computes every checksum, and all 256 byte values are swept both with and without junk upper bits.

// File: rtl/crc_engine_pkg.sv
package crc_engine_pkg;

  localparam int REG_COUNT = 3;
  localparam int SEL_CTRL  = 0;
  localparam int SEL_DIN   = 1;
  localparam int SEL_DOUT  = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIN  = 2'd1;
  localparam logic [1:0] ADDR_DOUT = 2'd2;

  localparam int BYTE_W = 8;

  // Strobes from the bus decoder to the datapath
  typedef struct packed {
    logic              clear;
    logic              feed;
    logic [BYTE_W-1:0] dataByte;
  } crcStrobeT;

endpackage

// File: rtl/crc_engine_ctrl.sv
module crc_engine_ctrl
  import crc_engine_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 12,
  parameter int CRC_W   = 16,
  parameter int RST_BIT = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_COUNT-1:0] wrSel,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [1:0]           rdAddr,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [CRC_W-1:0]     crcOut,
  output crcStrobeT            strobes,
  output logic [DATA_W-1:0]    rdData
);

  localparam int CNT_PAD = DATA_W - CNT_W;
  localparam int CRC_PAD = DATA_W - CRC_W;

  logic clearReq;
  logic feedReq;

  // Clear has priority over a byte arriving in the same cycle
  always_comb begin
    clearReq = wrSel[SEL_CTRL] && wrData[RST_BIT];
    feedReq  = wrSel[SEL_DIN] && !clearReq;
    strobes.clear    = clearReq;
    strobes.feed     = feedReq;
    strobes.dataByte = wrData[BYTE_W-1:0];
  end

  // Read mux; the reset bit and the upper control bits read as zero
  always_comb begin
    unique case (rdAddr)
      ADDR_CTRL: rdData = {{CNT_PAD{1'b0}}, cnt};
      ADDR_DOUT: rdData = {{CRC_PAD{1'b0}}, crcOut};
      default:   rdData = '0;
    endcase
  end

  AST_CLEAR_BEATS_FEED: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel[SEL_CTRL] && wrData[RST_BIT] && wrSel[SEL_DIN]) |-> (strobes.clear && !strobes.feed)); // R8

  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_CTRL) |-> (rdData[DATA_W-1:CNT_W] == '0)); // R3

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_DIN || rdAddr == 2'd3) |-> (rdData == '0)); // R9

endmodule

// File: rtl/crc_engine_datapath.sv
module crc_engine_datapath
  import crc_engine_pkg::*;
#(
  parameter int              CNT_W   = 12,
  parameter int              CRC_W   = 16,
  parameter logic [CRC_W-1:0] POLY    = 16'h1021,
  parameter logic [CRC_W-1:0] INIT    = 16'hFFFF,
  parameter logic [CRC_W-1:0] XOR_OUT = 16'hFFFF,
  parameter bit              REFLECT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  crcStrobeT        strobes,
  output logic [CNT_W-1:0] cnt,
  output logic [CRC_W-1:0] crcOut
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CRC_W-1:0] bitReverse(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] POLY_REV = bitReverse(POLY);

  logic [CRC_W-1:0] crcAcc;
  logic [CRC_W-1:0] stepped;
  logic [CNT_W-1:0] cntNext;

  generate
    if (REFLECT) begin : g_lsbFirst
      logic [CRC_W-1:0] work;
      always_comb begin
        work = crcAcc ^ {{(CRC_W-BYTE_W){1'b0}}, strobes.dataByte};
        for (int i = 0; i < BYTE_W; i++) begin
          work = work[0] ? ((work >> 1) ^ POLY_REV) : (work >> 1);
        end
        stepped = work;
      end
    end else begin : g_msbFirst
      logic [CRC_W-1:0] work;
      always_comb begin
        work = crcAcc ^ {strobes.dataByte, {(CRC_W-BYTE_W){1'b0}}};
        for (int i = 0; i < BYTE_W; i++) begin
          work = work[CRC_W-1] ? ((work << 1) ^ POLY) : (work << 1);
        end
        stepped = work;
      end
    end
  endgenerate

  always_comb begin
    cntNext = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcAcc <= INIT;
      cnt    <= '0;
    end else if (strobes.clear) begin
      crcAcc <= INIT;
      cnt    <= '0;
    end else if (strobes.feed) begin
      crcAcc <= stepped;
      cnt    <= cntNext;
    end
  end

  assign crcOut = crcAcc ^ XOR_OUT;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (cnt == '0 && crcOut == (INIT ^ XOR_OUT))); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.feed && !strobes.clear && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.feed && !strobes.clear && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.feed && !strobes.clear) |=> ($stable(cnt) && $stable(crcOut))); // R4

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_engine_pkg::*;
#(
  parameter int               DATA_W  = 16,
  parameter int               CNT_W   = 12,
  parameter int               CRC_W   = 16,
  parameter int               RST_BIT = 15,
  parameter logic [CRC_W-1:0] POLY    = 16'h1021,
  parameter logic [CRC_W-1:0] INIT    = 16'hFFFF,
  parameter logic [CRC_W-1:0] XOR_OUT = 16'hFFFF,
  parameter bit               REFLECT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData
);

  crcStrobeT        strobes;
  logic [CNT_W-1:0] cnt;
  logic [CRC_W-1:0] crcOut;

  crc_engine_ctrl #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .CRC_W  (CRC_W),
    .RST_BIT(RST_BIT)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrSel  (wrSel),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .cnt    (cnt),
    .crcOut (crcOut),
    .strobes(strobes),
    .rdData (rdData)
  );

  crc_engine_datapath #(
    .CNT_W  (CNT_W),
    .CRC_W  (CRC_W),
    .POLY   (POLY),
    .INIT   (INIT),
    .XOR_OUT(XOR_OUT),
    .REFLECT(REFLECT)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .cnt    (cnt),
    .crcOut (crcOut)
  );

endmodule

// File: tb/crc_engine_tb_top.sv
module crc_engine_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  wrSel = 3'b000;
  logic [15:0] wrData = 16'h0000;
  logic [1:0]  rdAddr = 2'd0;
  logic [15:0] rdData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] refCrc;
  int          refCnt;

  always #10 clk = ~clk;

  crc_engine dut_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrSel (wrSel),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

  // Reference: feed data bits one at a time into the low end, reflected polynomial
  function automatic logic [15:0] refStep(input logic [15:0] cur, input logic [7:0] b);
    logic [15:0] c;
    logic fb;
    c = cur;
    for (int k = 0; k < 8; k++) begin
      fb = c[0] ^ b[k];
      c  = {1'b0, c[15:1]};
      if (fb) c = c ^ 16'h8408;
    end
    return c;
  endfunction

  task automatic refClear();
    refCrc = 16'hFFFF;
    refCnt = 0;
  endtask

  task automatic refFeed(input logic [7:0] b);
    refCrc = refStep(refCrc, b);
    if (refCnt < 4095) refCnt++;
  endtask

  task automatic doWrite(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    wrSel  = sel;
    wrData = d;
    @(negedge clk);
    wrSel  = 3'b000;
    wrData = 16'h0000;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic checkEq(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkState(input string req);
    logic [15:0] v;
    readReg(2'd0, v);
    checkEq(req, v, 16'(refCnt));
    readReg(2'd2, v);
    checkEq(req, v, refCrc ^ 16'hFFFF);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired, actual running expected finished");
    finishRun();
  end

  initial begin
    logic [15:0] v;
    refClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    readReg(2'd0, v); checkEq("R1 ctrl after reset", v, 16'h0000);
    readReg(2'd2, v); checkEq("R1 result after reset", v, 16'h0000);
    // R9: write-only and unmapped reads
    readReg(2'd1, v); checkEq("R9 din reads zero", v, 16'h0000);
    readReg(2'd3, v); checkEq("R9 addr3 reads zero", v, 16'h0000);

    // R6: known-answer vector
    doWrite(3'b010, 16'h00CC); refFeed(8'hCC);
    doWrite(3'b010, 16'h00F5); refFeed(8'hF5);
    doWrite(3'b010, 16'h00F1); refFeed(8'hF1);
    doWrite(3'b010, 16'h00A7); refFeed(8'hA7);
    readReg(2'd0, v); checkEq("R6 count", v, 16'h0004);
    readReg(2'd2, v); checkEq("R6 result", v, 16'h51DF);

    // R2: control write without reset bit is ignored; R3 upper bits zero
    doWrite(3'b001, 16'h7FFF);
    checkState("R2 ctrl write w/o reset bit");
    readReg(2'd0, v); checkEq("R3 upper ctrl bits", v & 16'hF000, 16'h0000);
    // R9: result register write ignored
    doWrite(3'b100, 16'h1234);
    checkState("R9 write to result ignored");
    // R2: clear
    doWrite(3'b001, 16'h8000); refClear();
    checkState("R2 clear");
    readReg(2'd0, v); checkEq("R3 reset bit reads 0", v, 16'h0000);

    // R4: sweep every byte value
    for (int b = 0; b < 256; b++) begin
      doWrite(3'b010, 16'(b)); refFeed(8'(b));
      checkState("R4 byte sweep");
    end

    // R5: upper bits ignored
    doWrite(3'b001, 16'h8000); refClear();
    for (int b = 0; b < 256; b++) begin
      logic [15:0] d;
      d = {4'(b * 7 + 3), 4'(b + 9), 8'(b)};
      doWrite(3'b010, d); refFeed(8'(b));
      checkState("R5 upper bits ignored");
    end

    // R8: collision
    doWrite(3'b011, 16'h80AB); refClear();
    checkState("R8 clear wins");
    doWrite(3'b011, 16'h00AB); refFeed(8'hAB);
    checkState("R8 no reset bit, byte accepted");

    // R7: saturation
    doWrite(3'b001, 16'h8000); refClear();
    for (int i = 0; i < 4094; i++) begin
      doWrite(3'b010, 16'(i)); refFeed(8'(i));
    end
    checkState("R7 count 0xFFE");
    doWrite(3'b010, 16'h005A); refFeed(8'h5A);
    readReg(2'd0, v); checkEq("R7 count at max", v, 16'h0FFF);
    for (int i = 0; i < 3; i++) begin
      doWrite(3'b010, 16'(i + 17)); refFeed(8'(i + 17));
      readReg(2'd0, v); checkEq("R7 count holds", v, 16'h0FFF);
      readReg(2'd2, v); checkEq("R7 crc still updates", v, refCrc ^ 16'hFFFF);
    end
    doWrite(3'b001, 16'h8000); refClear();
    checkState("R2 clear from saturation");

    finishRun();
  end

endmodule